// File: doc/BRIEF.md
# Prioritised Seven-Level Interrupt Recogniser

This block sits between a processor core and its seven active-low external interrupt request lines. Each line is synchronised to the core clock. The block then checks the requests against the interrupt mask, which it holds on the core's behalf. It presents one pending strobe together with the number of the winning level. Levels one to six are masked and sensed by level. A line held low is offered again whenever the mask falls below its number.

Level seven cannot be masked and behaves differently. A falling edge produces one request, guarded by a recognition latch. The latch re-arms when the line goes high or when the core writes its status register. As a result, a return from exception with the line still low produces a fresh request without any new edge. When the core accepts the strobe, it raises the mask to the level it took. The core reloads the mask through the status-write strobe, for example when it returns from a handler.

Top module: `irq_prio_recognizer`

## Requirements
- R1: After reset the mask output is 7, the pending output is low, the pending level is 0 and the acknowledged-level output is 0.
- R2: Every request line passes through a two-flop synchroniser. A change on line 1 to 6 reaches the pending outputs on the second rising edge after it is applied. A level-7 falling edge reaches them on the third rising edge.
- R3: Lines for levels 1 to 6 are level sensitive. A line held low qualifies only while its level number is strictly greater than the current mask. A level equal to or below the mask is blocked.
- R4: Bit k of the request input is level k+1. When several levels qualify, the pending level output shows the highest-numbered one.
- R5: The pending output stays high until an acknowledge arrives. An acknowledge taken while pending loads the mask and the acknowledged-level output with the pending level. An acknowledge while nothing is pending changes neither output.
- R6: A status write loads the mask from the data input, so a line 1 to 6 still held low is offered again as soon as the mask drops below it. If an accepted acknowledge and a status write fall in the same cycle, the acknowledged level is loaded into the mask.
- R7: Level 7 ignores the mask. A falling edge on its line raises a level-7 request even when the mask is 7.
- R8: After a level-7 request is acknowledged, a line that stays low and sees no status write raises no further request.
- R9: If the level-7 line goes high and then low again, a new level-7 request is raised, even while the mask is 7.
- R10: A status write while the level-7 line is low re-arms the latch and raises a new level-7 request with no new edge. A status write while the line is high raises none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_n_i | input | 7 | Active-low request lines; bit k is level k+1 |
| ack_i | input | 1 | Core accepts the pending interrupt |
| sr_wr_i | input | 1 | Status-register write strobe (also on return from exception) |
| sr_data_i | input | 3 | Mask value carried by a status write |
| mask_o | output | 3 | Current interrupt mask |
| int_pend_o | output | 1 | An interrupt is pending |
| int_lvl_o | output | 3 | Level of the pending interrupt, 0 when none |
| ack_lvl_o | output | 3 | Level taken by the last accepted acknowledge |

## Verification
The bench holds level-7 low across an acknowledge. This catches a design that treats the line as purely level-sensitive, which would re-interrupt endlessly. It then writes the status register with the line still low, which exposes a purely edge-triggered design: such a design would never fire again after a return. A mask equal to a request level is tested to catch an off-by-one comparison that admits the request. A simultaneous acknowledge and status write, and an acknowledge with nothing pending, expose mask-update priority mistakes that would corrupt the mask.

// File: rtl/irq_rec_pkg.sv
package irq_rec_pkg;
  localparam int LVL_W   = 3;
  localparam int NUM_LVL = (1 << LVL_W) - 1;
  localparam logic [LVL_W-1:0] TOP_LVL = '1;

  // Highest-numbered set bit, reported as level number (bit k -> k+1).
  function automatic logic [LVL_W-1:0] pick_level(input logic [NUM_LVL-1:0] qual);
    logic [LVL_W-1:0] lvl;
    lvl = '0;
    for (int k = 0; k < NUM_LVL; k++) begin
      if (qual[k]) lvl = LVL_W'(k + 1);
    end
    return lvl;
  endfunction

  // A maskable level passes only when strictly above the mask.
  function automatic logic above_mask(input int level, input logic [LVL_W-1:0] mask);
    return level > int'(mask);
  endfunction
endpackage

// File: rtl/irq_rec_sync.sv
module irq_rec_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '1;
        end else if (s == 0) begin
          stage_q[s] <= d_i;
        end else begin
          stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_rec_nmi.sv
module irq_rec_nmi (
  input  logic clk,
  input  logic rst_n,
  input  logic line_low_i,
  input  logic sr_wr_i,
  input  logic ack_top_i,
  output logic pend_o,
  output logic latch_o,
  output logic fire_o
);
  logic latch_q, pend_q;
  logic rearm_w;

  assign fire_o  = line_low_i && !latch_q;
  assign rearm_w = !line_low_i || sr_wr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
    end else if (fire_o) begin
      latch_q <= 1'b1;
    end else if (rearm_w) begin
      latch_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (fire_o) begin
      pend_q <= 1'b1;
    end else if (ack_top_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pend_o  = pend_q;
  assign latch_o = latch_q;
endmodule

// File: rtl/irq_rec_arb.sv
module irq_rec_arb
  import irq_rec_pkg::*;
(
  input  logic [NUM_LVL-1:0] req_i,
  input  logic [LVL_W-1:0]   mask_i,
  output logic               pend_o,
  output logic [LVL_W-1:0]   lvl_o
);
  logic [NUM_LVL-1:0] qual_w;

  generate
    for (genvar k = 0; k < NUM_LVL; k++) begin : g_qual
      if (k == NUM_LVL - 1) begin : g_top
        assign qual_w[k] = req_i[k];
      end else begin : g_masked
        assign qual_w[k] = req_i[k] && above_mask(k + 1, mask_i);
      end
    end
  endgenerate

  assign pend_o = |qual_w;
  assign lvl_o  = pick_level(qual_w);
endmodule

// File: rtl/irq_prio_recognizer.sv
module irq_prio_recognizer
  import irq_rec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] irq_n_i,
  input  logic               ack_i,
  input  logic               sr_wr_i,
  input  logic [LVL_W-1:0]   sr_data_i,
  output logic [LVL_W-1:0]   mask_o,
  output logic               int_pend_o,
  output logic [LVL_W-1:0]   int_lvl_o,
  output logic [LVL_W-1:0]   ack_lvl_o
);
  logic [NUM_LVL-1:0] sync_n_w;
  logic [NUM_LVL-1:0] req_w;
  logic [LVL_W-1:0]   mask_q, ack_lvl_q;
  logic               ack_take_w, ack_top_w;
  logic               nmi_line_low_w, nmi_pend_w, nmi_latch_w, nmi_fire_w;

  irq_rec_sync #(.W(NUM_LVL), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(irq_n_i), .q_o(sync_n_w)
  );

  assign nmi_line_low_w = !sync_n_w[NUM_LVL-1];

  irq_rec_nmi u_nmi (
    .clk(clk), .rst_n(rst_n), .line_low_i(nmi_line_low_w), .sr_wr_i(sr_wr_i),
    .ack_top_i(ack_top_w), .pend_o(nmi_pend_w), .latch_o(nmi_latch_w),
    .fire_o(nmi_fire_w)
  );

  assign req_w = {nmi_pend_w, ~sync_n_w[NUM_LVL-2:0]};

  irq_rec_arb u_arb (
    .req_i(req_w), .mask_i(mask_q), .pend_o(int_pend_o), .lvl_o(int_lvl_o)
  );

  assign ack_take_w = ack_i && int_pend_o;
  assign ack_top_w  = ack_take_w && (int_lvl_o == TOP_LVL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= TOP_LVL;
      ack_lvl_q <= '0;
    end else if (ack_take_w) begin
      mask_q    <= int_lvl_o;
      ack_lvl_q <= int_lvl_o;
    end else if (sr_wr_i) begin
      mask_q    <= sr_data_i;
    end
  end

  assign mask_o    = mask_q;
  assign ack_lvl_o = ack_lvl_q;
endmodule

// File: rtl/irq_prio_recognizer_chk.sv
module irq_prio_recognizer_chk
  import irq_rec_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ack_i,
  input logic             sr_wr_i,
  input logic [LVL_W-1:0] sr_data_i,
  input logic [LVL_W-1:0] mask_o,
  input logic             int_pend_o,
  input logic [LVL_W-1:0] int_lvl_o,
  input logic [LVL_W-1:0] ack_lvl_o,
  input logic             nmi_line_low_w,
  input logic             nmi_latch_w
);
  // R3
  pend_above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_pend_o |-> (int_lvl_o == TOP_LVL || int_lvl_o > mask_o));

  // R4
  idle_level_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !int_pend_o |-> int_lvl_o == '0);

  // R5
  ack_loads_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && int_pend_o) |=> (mask_o == $past(int_lvl_o) && ack_lvl_o == $past(int_lvl_o)));

  // R5
  ack_lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_i && int_pend_o) |=> $stable(ack_lvl_o));

  // R6
  sr_write_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr_i && !(ack_i && int_pend_o)) |=> mask_o == $past(sr_data_i));

  // R8
  nmi_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_latch_w && nmi_line_low_w && !sr_wr_i) |=> nmi_latch_w);

  // R9
  nmi_rearm_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_line_low_w |=> !nmi_latch_w);
endmodule

bind irq_prio_recognizer irq_prio_recognizer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .sr_wr_i(sr_wr_i), .sr_data_i(sr_data_i),
  .mask_o(mask_o), .int_pend_o(int_pend_o), .int_lvl_o(int_lvl_o), .ack_lvl_o(ack_lvl_o),
  .nmi_line_low_w(nmi_line_low_w), .nmi_latch_w(nmi_latch_w)
);

// File: tb/irq_prio_recognizer_tb_top.sv
module irq_prio_recognizer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] irq_n = 7'h7f;
  logic       ack = 1'b0;
  logic       srw = 1'b0;
  logic [2:0] srd = 3'd0;
  logic [2:0] mask, lvl, ack_lvl;
  logic       pend;
  int         n_chk = 0;
  int         n_fail = 0;

  always #5 clk = ~clk;

  irq_prio_recognizer dut_i (
    .clk(clk), .rst_n(rst_n), .irq_n_i(irq_n), .ack_i(ack), .sr_wr_i(srw),
    .sr_data_i(srd), .mask_o(mask), .int_pend_o(pend), .int_lvl_o(lvl),
    .ack_lvl_o(ack_lvl)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sr_write(input logic [2:0] v);
    srw = 1'b1; srd = v; step(1); srw = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; step(1); ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "mask", mask, 7);
    chk("R1", "pend", pend, 0);
    chk("R1", "lvl", lvl, 0);
    chk("R1", "ack_lvl", ack_lvl, 0);
  endtask

  task automatic t_level_prio();
    sr_write(3'd0);
    irq_n[2] = 1'b0;
    step(1); chk("R2", "pend after one edge", pend, 0);
    step(1); chk("R3", "pend lvl3", pend, 1); chk("R3", "lvl", lvl, 3);
    irq_n[4] = 1'b0;
    step(2); chk("R4", "lvl5 wins", lvl, 5);
    do_ack();
    chk("R5", "mask after ack", mask, 5);
    chk("R5", "ack_lvl", ack_lvl, 5);
    chk("R3", "pend blocked", pend, 0);
    sr_write(3'd2);
    chk("R6", "re-offered after return", pend, 1);
    chk("R6", "lvl", lvl, 5);
    irq_n = 7'h7f; step(2);
    chk("R3", "released", pend, 0);
  endtask

  task automatic t_mask_equal();
    sr_write(3'd4);
    irq_n[3] = 1'b0; step(3);
    chk("R3", "equal mask blocks", pend, 0);
    sr_write(3'd3);
    chk("R3", "lower mask passes", lvl, 4);
    irq_n = 7'h7f; step(2);
  endtask

  task automatic t_ack_idle();
    chk("R5", "idle", pend, 0);
    do_ack();
    chk("R5", "idle ack mask", mask, 3);
    chk("R5", "idle ack lvl", ack_lvl, 5);
  endtask

  task automatic t_nmi_edge();
    sr_write(3'd7);
    irq_n[6] = 1'b0;
    step(2); chk("R2", "nmi after two edges", pend, 0);
    step(1); chk("R7", "nmi pend under mask 7", pend, 1); chk("R7", "lvl", lvl, 7);
    do_ack();
    chk("R7", "ack_lvl", ack_lvl, 7);
    step(5); chk("R8", "no refire while held", pend, 0);
  endtask

  task automatic t_nmi_reedge();
    irq_n[6] = 1'b1; step(3);
    irq_n[6] = 1'b0; step(3);
    chk("R9", "new edge refires", pend, 1);
    chk("R9", "lvl", lvl, 7);
    do_ack();
  endtask

  task automatic t_sr_refire();
    sr_write(3'd0);
    chk("R10", "not yet", pend, 0);
    step(1);
    chk("R10", "refire on write", pend, 1);
    chk("R10", "lvl", lvl, 7);
    do_ack();
    irq_n[6] = 1'b1; step(3);
    sr_write(3'd0); step(3);
    chk("R10", "write with line high", pend, 0);
  endtask

  task automatic t_nmi_vs_six();
    irq_n[5] = 1'b0; step(2);
    chk("R4", "lvl6", lvl, 6);
    irq_n[6] = 1'b0; step(3);
    chk("R4", "nmi beats 6", lvl, 7);
    do_ack();
    chk("R3", "6 blocked by 7", pend, 0);
    sr_write(3'd5);
    chk("R6", "lvl6 back first", lvl, 6);
    step(1);
    chk("R10", "nmi refire after write", lvl, 7);
    do_ack();
    irq_n = 7'h7f; step(3);
    sr_write(3'd0); step(3);
    chk("R10", "all quiet", pend, 0);
  endtask

  task automatic t_ack_and_write();
    irq_n[1] = 1'b0; step(2);
    chk("R3", "lvl2", lvl, 2);
    ack = 1'b1; srw = 1'b1; srd = 3'd6; step(1); ack = 1'b0; srw = 1'b0;
    chk("R6", "ack wins mask", mask, 2);
    irq_n = 7'h7f; step(2);
  endtask

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(1);
    t_level_prio();
    t_mask_equal();
    t_ack_idle();
    t_nmi_edge();
    t_nmi_reedge();
    t_sr_refire();
    t_nmi_vs_six();
    t_ack_and_write();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule